// File: doc/BRIEF.md
# Command-Unlock Chip Erase Sequencer

This block is host-side control logic that wipes an entire byte-wide nonvolatile memory. A single start request launches it. It issues a two-write command sequence: an unlock write, then an erase write, each held for its own strobe length. It then walks every location in ascending order in high-voltage verify mode and looks for the erased value 0xFF.

When a location still holds programmed bits, the sequencer issues the two commands again. It then resumes checking at that same location rather than at location zero. This repeats until the configured attempt limit is used up. Once every location has verified, the supply mode returns to normal read and a second full walk confirms that every byte reads 0xFF. At the end the block reports pass or fail, the location that failed, and how many erase attempts it used. The supply-voltage switching is shown only as a mode flag.

Top module: `erase_sequencer`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, pass_o, strobe_o, dev_we_o, rd_en_o and hv_mode_o are all low.
- R2: Every attempt starts with an unlock write. dev_addr_o is 0x5555, dev_wdata_o is 0xAA, dev_we_o is high, and strobe_o stays high for exactly UNLOCK_CYC consecutive cycles.
- R3: The unlock write is followed by one cycle with strobe_o low. Then comes the erase write: dev_addr_o is 0x2AAA, dev_wdata_o is 0x10, and strobe_o is high for exactly ERASE_CYC cycles. One cycle with strobe_o low follows, and verify begins in the cycle after that.
- R4: Verify reads assert rd_en_o with hv_mode_o high. They start at address 0 and move up by one address per cycle while rd_data_i equals 0xFF.
- R5: When a verify read returns anything other than 0xFF and fewer than MAX_TRIES attempts have been made, the sequencer issues the unlock and erase writes again. It then resumes verify at the same address, so a run that passes uses DEPTH plus (attempts minus one) verify reads.
- R6: When a verify read misses and MAX_TRIES attempts have already been made, the run ends with pass_o low, fail_addr_o set to that address, and tries_o equal to MAX_TRIES.
- R7: After address DEPTH-1 verifies, a final walk from address 0 reads with rd_en_o high and hv_mode_o low. If every byte is 0xFF, the run ends with pass_o high and fail_addr_o zero. At the first byte that is not 0xFF, the run ends with pass_o low and fail_addr_o set to that address.
- R8: done_o is a one-cycle pulse at the end of a run. busy_o stays high from the cycle after start_i is accepted until done_o, and is low in the cycle after done_o.
- R9: start_i has no effect while busy_o is high. The run in progress continues, and the number of attempts and the outcome are unchanged.
- R10: tries_o holds the number of erase writes issued in the last run, and it stays valid after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the last run |
| fail_addr_o | output | ADDR_W | Address that ended a failed run |
| tries_o | output | TRY_W | Erase attempts used in the last run |
| dev_addr_o | output | ADDR_W | Device address |
| dev_wdata_o | output | DATA_W | Command data driven to the device |
| dev_we_o | output | 1 | Command data drive enable |
| strobe_o | output | 1 | Command write strobe |
| rd_en_o | output | 1 | Read cycle in progress |
| hv_mode_o | output | 1 | High-voltage (erase/verify) supply mode flag |
| rd_data_i | input | DATA_W | Read data from the device |

## Verification
If a wrong internal state occurs, it shows up at the ports within one command or one read. A timer that is off by one changes a strobe width that is measured from edge to edge. A verify address that is reset after a retry adds extra reads to the verify count. A retry counter that is off by one changes both tries_o and the number of command pairs seen on the bus. The device model makes chosen addresses need a set number of erases, or read badly only in normal mode. This drives the resume path, the limit boundary on both sides, and the final walk, and the sequence of addresses is checked on every read.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNLOCK,
        S_GAP1,
        S_ERASE,
        S_GAP2,
        S_VERIFY,
        S_FINAL,
        S_DONE
    } seq_state_e;

    localparam logic [15:0] CMD_UNLOCK_ADDR = 16'h5555;
    localparam logic [7:0]  CMD_UNLOCK_DATA = 8'hAA;
    localparam logic [15:0] CMD_ERASE_ADDR  = 16'h2AAA;
    localparam logic [7:0]  CMD_ERASE_DATA  = 8'h10;
    localparam logic [7:0]  BLANK_BYTE      = 8'hFF;

endpackage

// File: rtl/es_pulse_timer.sv
module es_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = len_i - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R2 / R3: the count only moves down unless reloaded
    p_timer_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/es_try_counter.sv
module es_try_counter #(
    parameter int MAX_TRIES = 20,
    parameter int TRY_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_i,
    input  logic             inc_i,
    output logic [TRY_W-1:0] count_o,
    output logic             at_max_o
);

    logic [TRY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (first_i)
            cnt_d = TRY_W'(1);
        else if (inc_i)
            cnt_d = cnt_q + TRY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o  = cnt_q;
    assign at_max_o = (cnt_q >= TRY_W'(MAX_TRIES));

    // R6: never asked to go past the attempt limit
    p_no_inc_at_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !at_max_o);

    // R10: the count never exceeds the limit
    p_tries_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TRY_W'(MAX_TRIES));

endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 65536,
    parameter int UNLOCK_CYC = 2500,
    parameter int ERASE_CYC  = 5000000,
    parameter int MAX_TRIES  = 20,
    localparam int TRY_W     = $clog2(MAX_TRIES + 1),
    localparam int LONGEST   = (ERASE_CYC > UNLOCK_CYC) ? ERASE_CYC : UNLOCK_CYC,
    localparam int CNT_W     = $clog2(LONGEST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [TRY_W-1:0]  tries_o,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic [DATA_W-1:0] dev_wdata_o,
    output logic              dev_we_o,
    output logic              strobe_o,
    output logic              rd_en_o,
    output logic              hv_mode_o,
    input  logic [DATA_W-1:0] rd_data_i
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] A_UNLOCK  = ADDR_W'(CMD_UNLOCK_ADDR);
    localparam logic [ADDR_W-1:0] A_ERASE   = ADDR_W'(CMD_ERASE_ADDR);
    localparam logic [DATA_W-1:0] D_UNLOCK  = DATA_W'(CMD_UNLOCK_DATA);
    localparam logic [DATA_W-1:0] D_ERASE   = DATA_W'(CMD_ERASE_DATA);
    localparam logic [DATA_W-1:0] D_BLANK   = DATA_W'(BLANK_BYTE);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              pass;
        logic [ADDR_W-1:0] fail_addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_expired;
    logic             try_first;
    logic             try_inc;
    logic             try_at_max;
    logic [TRY_W-1:0] try_count;
    logic             byte_blank;

    es_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_expired)
    );

    es_try_counter #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .first_i  (try_first),
        .inc_i    (try_inc),
        .count_o  (try_count),
        .at_max_o (try_at_max)
    );

    assign byte_blank = (rd_data_i == D_BLANK);

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_len   = CNT_W'(UNLOCK_CYC);
        try_first = 1'b0;
        try_inc   = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.st        = S_UNLOCK;
                    r_d.addr      = '0;
                    r_d.pass      = 1'b0;
                    r_d.fail_addr = '0;
                    tmr_load      = 1'b1;
                    try_first     = 1'b1;
                end
            end
            S_UNLOCK: if (tmr_expired) r_d.st = S_GAP1;
            S_GAP1: begin
                r_d.st   = S_ERASE;
                tmr_load = 1'b1;
                tmr_len  = CNT_W'(ERASE_CYC);
            end
            S_ERASE: if (tmr_expired) r_d.st = S_GAP2;
            S_GAP2:  r_d.st = S_VERIFY;
            S_VERIFY: begin
                if (byte_blank) begin
                    if (r_q.addr == LAST_ADDR) begin
                        r_d.st   = S_FINAL;
                        r_d.addr = '0;
                    end else begin
                        r_d.addr = r_q.addr + ADDR_W'(1);
                    end
                end else if (try_at_max) begin
                    r_d.st        = S_DONE;
                    r_d.pass      = 1'b0;
                    r_d.fail_addr = r_q.addr;
                end else begin
                    r_d.st   = S_UNLOCK;
                    tmr_load = 1'b1;
                    try_inc  = 1'b1;
                end
            end
            S_FINAL: begin
                if (!byte_blank) begin
                    r_d.st        = S_DONE;
                    r_d.pass      = 1'b0;
                    r_d.fail_addr = r_q.addr;
                end else if (r_q.addr == LAST_ADDR) begin
                    r_d.st   = S_DONE;
                    r_d.pass = 1'b1;
                end else begin
                    r_d.addr = r_q.addr + ADDR_W'(1);
                end
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= S_IDLE;
            r_q.addr      <= '0;
            r_q.pass      <= 1'b0;
            r_q.fail_addr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        dev_addr_o  = r_q.addr;
        dev_wdata_o = '0;
        if (r_q.st == S_UNLOCK || r_q.st == S_GAP1) begin
            dev_addr_o  = A_UNLOCK;
            dev_wdata_o = D_UNLOCK;
        end else if (r_q.st == S_ERASE || r_q.st == S_GAP2) begin
            dev_addr_o  = A_ERASE;
            dev_wdata_o = D_ERASE;
        end
    end

    assign strobe_o    = (r_q.st == S_UNLOCK) || (r_q.st == S_ERASE);
    assign dev_we_o    = (r_q.st == S_UNLOCK) || (r_q.st == S_GAP1) ||
                         (r_q.st == S_ERASE)  || (r_q.st == S_GAP2);
    assign rd_en_o     = (r_q.st == S_VERIFY) || (r_q.st == S_FINAL);
    assign hv_mode_o   = (r_q.st != S_IDLE) && (r_q.st != S_FINAL) && (r_q.st != S_DONE);
    assign busy_o      = (r_q.st != S_IDLE);
    assign done_o      = (r_q.st == S_DONE);
    assign pass_o      = r_q.pass;
    assign fail_addr_o = r_q.fail_addr;
    assign tries_o     = try_count;

    p_cmd_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (dev_we_o && (dev_addr_o == A_UNLOCK || dev_addr_o == A_ERASE)));

    p_erase_to_verify_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strobe_o) && dev_addr_o == A_ERASE) |=> (rd_en_o && hv_mode_o));

    p_verify_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && hv_mode_o && byte_blank && dev_addr_o != LAST_ADDR)
        |=> (rd_en_o && hv_mode_o && dev_addr_o == $past(dev_addr_o) + ADDR_W'(1)));

    p_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && hv_mode_o && !byte_blank && tries_o < TRY_W'(MAX_TRIES))
        |=> (strobe_o && dev_addr_o == A_UNLOCK));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_no_read_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !strobe_o);

endmodule

// File: tb/erase_sequencer_tb.sv
module erase_sequencer_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int UCYC   = 3;
    localparam int ECYC   = 6;
    localparam int MAXT   = 4;
    localparam int TRY_W  = $clog2(MAXT + 1);

    typedef struct packed {
        logic [3:0] slow_addr;
        logic [3:0] slow_need;
        logic [3:0] base_need;
        logic       weak_en;
        logic [3:0] weak_addr;
        logic       busy_start;
        logic       exp_pass;
        logic [3:0] exp_tries;
        logic [3:0] exp_fail;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  4'd1, 4'd1, 1'b0, 4'd0, 1'b0, 1'b1, 4'd1, 4'd0},
        '{4'd9,  4'd3, 4'd1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd3, 4'd0},
        '{4'd5,  4'd4, 4'd2, 1'b0, 4'd0, 1'b0, 1'b1, 4'd4, 4'd0},
        '{4'd7,  4'd5, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd4, 4'd7},
        '{4'd12, 4'd2, 4'd1, 1'b1, 4'd3, 1'b0, 1'b0, 4'd2, 4'd3},
        '{4'd0,  4'd5, 4'd5, 1'b0, 4'd0, 1'b1, 1'b0, 4'd4, 4'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              busy_o, done_o, pass_o;
    logic [ADDR_W-1:0] fail_addr_o;
    logic [TRY_W-1:0]  tries_o;
    logic [ADDR_W-1:0] dev_addr_o;
    logic [DATA_W-1:0] dev_wdata_o;
    logic              dev_we_o, strobe_o, rd_en_o, hv_mode_o;
    logic [DATA_W-1:0] rd_data_i;

    always #10 clk = ~clk;

    erase_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .UNLOCK_CYC(UCYC), .ERASE_CYC(ECYC), .MAX_TRIES(MAXT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
        .fail_addr_o(fail_addr_o), .tries_o(tries_o),
        .dev_addr_o(dev_addr_o), .dev_wdata_o(dev_wdata_o),
        .dev_we_o(dev_we_o), .strobe_o(strobe_o),
        .rd_en_o(rd_en_o), .hv_mode_o(hv_mode_o), .rd_data_i(rd_data_i)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    vec_t cfg     = '0;

    int erases, unlocks, vreads, freads, width, bad_width, bad_order, bad_cmd;
    int last_vaddr;
    logic armed;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;

    // device model: each byte blanks after a set number of erases
    always_comb begin
        int need;
        need = (dev_addr_o[3:0] == cfg.slow_addr) ? int'(cfg.slow_need) : int'(cfg.base_need);
        if (dev_addr_o >= ADDR_W'(DEPTH))
            rd_data_i = 8'hFF;
        else if (!hv_mode_o && cfg.weak_en && dev_addr_o[3:0] == cfg.weak_addr)
            rd_data_i = 8'h7F;
        else if (erases >= need)
            rd_data_i = 8'hFF;
        else
            rd_data_i = 8'h3C;
    end

    task automatic clear_mon();
        erases = 0; unlocks = 0; vreads = 0; freads = 0; width = 0;
        bad_width = 0; bad_order = 0; bad_cmd = 0; last_vaddr = -1; armed = 1'b0;
    endtask

    initial clear_mon();

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (strobe_o) begin
                width  = width + 1;
                s_addr = dev_addr_o;
                s_data = dev_wdata_o;
            end else if (width > 0) begin
                if (s_addr == 16'h5555 && s_data == 8'hAA) begin
                    if (width != UCYC) bad_width = bad_width + 1;
                    unlocks = unlocks + 1;
                    armed = 1'b1;
                end else if (s_addr == 16'h2AAA && s_data == 8'h10) begin
                    if (width != ECYC) bad_width = bad_width + 1;
                    if (!armed) bad_cmd = bad_cmd + 1;
                    armed = 1'b0;
                    erases = erases + 1;
                end else begin
                    bad_cmd = bad_cmd + 1;
                end
                width = 0;
            end
            if (rd_en_o && hv_mode_o) begin
                if (!(int'(dev_addr_o) == last_vaddr || int'(dev_addr_o) == last_vaddr + 1))
                    bad_order = bad_order + 1;
                last_vaddr = int'(dev_addr_o);
                vreads = vreads + 1;
            end
            if (rd_en_o && !hv_mode_o) freads = freads + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int waited;
        int exp_v, exp_f;
        bit verify_fail;
        cfg = v;
        clear_mon();
        @(negedge clk); #2;
        start_i = 1'b1;
        @(negedge clk); #2;
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
        if (v.busy_start) begin
            repeat (5) @(negedge clk);
            #2 start_i = 1'b1;
            @(negedge clk); #2;
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 5000) begin
            @(negedge clk); #2;
            waited = waited + 1;
        end
        chk(done_o == 1'b1, "R8 done seen", int'(done_o), 1);
        chk(pass_o == v.exp_pass, "R6/R7 pass", int'(pass_o), int'(v.exp_pass));
        chk(int'(tries_o) == int'(v.exp_tries), "R10 tries", int'(tries_o), int'(v.exp_tries));
        chk(int'(fail_addr_o) == int'(v.exp_fail), "R6/R7 fail address",
            int'(fail_addr_o), int'(v.exp_fail));
        chk(unlocks == int'(v.exp_tries), "R2 unlock count (R9 with busy start)",
            unlocks, int'(v.exp_tries));
        chk(erases == int'(v.exp_tries), "R3 erase count", erases, int'(v.exp_tries));
        chk(bad_width == 0, "R2/R3 strobe width", bad_width, 0);
        chk(bad_cmd == 0, "R3 command order", bad_cmd, 0);
        chk(bad_order == 0, "R4 verify address order", bad_order, 0);
        verify_fail = !v.exp_pass && !v.weak_en;
        exp_v = verify_fail ? int'(v.exp_fail) + int'(v.exp_tries)
                            : DEPTH + int'(v.exp_tries) - 1;
        chk(vreads == exp_v, "R5 verify reads (resume at failing address)", vreads, exp_v);
        exp_f = verify_fail ? 0 : (v.exp_pass ? DEPTH : int'(v.exp_fail) + 1);
        chk(freads == exp_f, "R7 final walk reads", freads, exp_f);
        @(negedge clk); #2;
        chk(done_o == 1'b0 && busy_o == 1'b0, "R8 single done pulse",
            int'({done_o, busy_o}), 0);
        chk(int'(tries_o) == int'(v.exp_tries), "R10 tries held", int'(tries_o),
            int'(v.exp_tries));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests = n_tests + 1;
        n_fail  = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk({busy_o, done_o, pass_o, strobe_o, dev_we_o, rd_en_o, hv_mode_o} == 7'b0,
            "R1 reset state",
            int'({busy_o, done_o, pass_o, strobe_o, dev_we_o, rd_en_o, hv_mode_o}), 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(busy_o == 1'b0 && strobe_o == 1'b0, "R1 idle after reset",
            int'({busy_o, strobe_o}), 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R9: start held high for a long stretch does not restart the run
        begin
            vec_t v;
            v = VECS[1];
            v.busy_start = 1'b0;
            cfg = v;
            clear_mon();
            @(negedge clk); #2;
            start_i = 1'b1;
            repeat (20) @(negedge clk);
            #2 start_i = 1'b0;
            while (!done_o) begin
                @(negedge clk); #2;
            end
            chk(unlocks == 3 && erases == 3, "R9 held start ignored", unlocks, 3);
            chk(vreads == DEPTH + 2, "R9 held start verify reads", vreads, DEPTH + 2);
        end

        // R1: reset in the middle of a run returns to idle
        cfg = VECS[0];
        @(negedge clk); #2;
        start_i = 1'b1;
        @(negedge clk); #2;
        start_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk); #2;
        chk(busy_o == 1'b0 && strobe_o == 1'b0 && pass_o == 1'b0, "R1 mid-run reset",
            int'({busy_o, strobe_o, pass_o}), 0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule